// File: doc/BRIEF.md
# Settable Hours-Minutes Countdown Timer

This block is a countdown timer that runs from the system clock. The default rate is 50 MHz. The user sets the preset in hours and minutes, and the preset can be as long as 24 hours. Two single-cycle press inputs drive the block. The step press moves a four-state control loop: hour setting, minute setting, counting and halted. The bump press adds one to the field that is being set.

The block shows the remaining time as two BCD bytes that a neighbour renders as hh:mm. It also outputs the control state and a finished flag. A seconds counter that is not visible, fed by a one-second prescaler, sets the rate at which minutes drop. Counting continues whatever the rest of the system is showing.

Every pin is a plain control or status level. No data stream crosses the block's edge, so no valid/ready handshake and no back-pressure exist. A press is taken in the cycle in which it is high.

Top module: `hm_countdown`

## Requirements
- R1: A synchronous reset gives time 00:00, state code 0 (hour setting) and `done` low, all visible in the cycle after the reset edge.
- R2: Each step press moves `state_o` along the codes 0 (hour setting), 1 (minute setting), 2 (counting), 3 (halted) and then back to 0.
- R3: In state 0, a bump press adds one to the hours. The hours go up to the preset limit 24 and then wrap to 0. Reaching 24 forces the minutes to 0.
- R4: In state 1, a bump press adds one to the minutes, which wrap from 59 to 0. While the hours read 24, the minutes stay at 0.
- R5: A bump press in state 2 or state 3 leaves the shown time and the state unchanged.
- R6: Entering state 2 restarts the hidden seconds at 59 and the prescaler at zero. The minutes first drop exactly 60 × `TICK_CYCLES` cycles after the entering press edge.
- R7: When a minute expires with the minutes at 00, the hours drop by one and the minutes become 59.
- R8: When the time reads 00:00 and the hidden seconds are 0 in state 2, the next edge sets state 3 and raises `done`. A preset of 00:mm finishes (60·mm + 59) · `TICK_CYCLES` + 1 cycles after the entering press edge.
- R9: A step press while `done` is high clears `done` and returns to state 0. The remaining time (00:00) is kept as the new preset.
- R10: A step press in state 2 halts the count (state 3) with `done` low. The time then holds, and the next step press returns to state 0 with that remaining time kept as the preset.
- R11: If a step press arrives in the same cycle as expiry, expiry wins: the state becomes 3 and `done` goes high.
- R12: If a step press and a bump press arrive in the same cycle, the bump acts on the field of the state that held in that cycle, and the state still advances.
- R13: `hours_bcd` and `minutes_bcd` carry the tens digit in bits [7:4] and the units digit in bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| step_press | input | 1 | One-cycle press that advances the control state |
| bump_press | input | 1 | One-cycle press that adds one to the field being set |
| hours_bcd | output | 8 | Remaining hours as two BCD digits |
| minutes_bcd | output | 8 | Remaining minutes as two BCD digits |
| state_o | output | 2 | Control state code (0 hours, 1 minutes, 2 counting, 3 halted) |
| done | output | 1 | High from expiry until the next step press |

## Verification
Two pairs of events can fall in one cycle. The first pair is a step press and expiry. The bench provokes this by placing the step press exactly in the cycle after the count reaches 00:00 with the hidden seconds at zero. The bench then requires the halted state with `done` high rather than the plain pause result. The second pair is a step press and a bump press. The bench drives both together in the hour-setting and minute-setting states. It judges the result by whether the increment landed on the field of the old state while the state still moved on.

// File: rtl/hmt_pkg.sv
package hmt_pkg;
  typedef enum logic [1:0] {
    ST_SET_HR  = 2'd0,
    ST_SET_MIN = 2'd1,
    ST_RUN     = 2'd2,
    ST_HALT    = 2'd3
  } tmr_state_e;
endpackage

// File: rtl/hmt_prescaler.sv
module hmt_prescaler #(
  parameter int TICK_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (en)
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/hmt_ctrl.sv
module hmt_ctrl
  import hmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step_press,
  input  logic       expire,
  output tmr_state_e state,
  output logic       done,
  output logic       start
);
  assign start = step_press && (state == ST_SET_MIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_SET_HR;
      done  <= 1'b0;
    end else if (expire) begin
      state <= ST_HALT;
      done  <= 1'b1;
    end else if (step_press) begin
      case (state)
        ST_SET_HR:  state <= ST_SET_MIN;
        ST_SET_MIN: state <= ST_RUN;
        ST_RUN:     state <= ST_HALT;
        default: begin
          state <= ST_SET_HR;
          done  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/hmt_clock.sv
module hmt_clock
  import hmt_pkg::*;
#(
  parameter int MAX_HOURS = 24,
  parameter int HW = 5,
  parameter int MW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  tmr_state_e    state,
  input  logic          bump_press,
  input  logic          start,
  input  logic          tick,
  output logic [HW-1:0] hours,
  output logic [MW-1:0] minutes,
  output logic          expire
);
  localparam logic [HW-1:0] HMAX = HW'(MAX_HOURS);
  localparam logic [MW-1:0] MLAST = MW'(59);

  logic [MW-1:0] secs;

  assign expire = (state == ST_RUN) && (hours == '0) && (minutes == '0) && (secs == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hours   <= '0;
      minutes <= '0;
      secs    <= '0;
    end else begin
      if (start)
        secs <= MLAST;
      else if (tick) begin
        if (secs != '0)
          secs <= secs - 1'b1;
        else if (minutes != '0) begin
          minutes <= minutes - 1'b1;
          secs    <= MLAST;
        end else if (hours != '0) begin
          hours   <= hours - 1'b1;
          minutes <= MLAST;
          secs    <= MLAST;
        end
      end
      if (bump_press) begin
        if (state == ST_SET_HR) begin
          if (hours == HMAX)
            hours <= '0;
          else begin
            hours <= hours + 1'b1;
            if (hours + 1'b1 == HMAX)
              minutes <= '0;
          end
        end else if (state == ST_SET_MIN && hours != HMAX) begin
          minutes <= (minutes == MLAST) ? '0 : minutes + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hmt_bcd.sv
module hmt_bcd #(
  parameter int W = 6
) (
  input  logic [W-1:0] bin,
  output logic [7:0]   bcd
);
  logic [W-1:0] tens;
  logic [W-1:0] units;

  always_comb begin
    tens  = bin / W'(10);
    units = bin % W'(10);
    bcd   = {tens[3:0], units[3:0]};
  end
endmodule

// File: rtl/hm_countdown.sv
module hm_countdown
  import hmt_pkg::*;
#(
  parameter int TICK_CYCLES = 50_000_000,
  parameter int MAX_HOURS   = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step_press,
  input  logic       bump_press,
  output logic [7:0] hours_bcd,
  output logic [7:0] minutes_bcd,
  output logic [1:0] state_o,
  output logic       done
);
  localparam int HW = $clog2(MAX_HOURS + 1);
  localparam int MW = 6;

  tmr_state_e    state;
  logic          start;
  logic          expire;
  logic          tick;
  logic [HW-1:0] hours;
  logic [MW-1:0] minutes;

  hmt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .step_press(step_press), .expire(expire),
    .state(state), .done(done), .start(start)
  );

  hmt_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
    .clk(clk), .rst(rst), .clr(start), .en(state == ST_RUN), .tick(tick)
  );

  hmt_clock #(.MAX_HOURS(MAX_HOURS), .HW(HW), .MW(MW)) u_time (
    .clk(clk), .rst(rst), .state(state), .bump_press(bump_press),
    .start(start), .tick(tick), .hours(hours), .minutes(minutes),
    .expire(expire)
  );

  hmt_bcd #(.W(HW)) u_hr_bcd  (.bin(hours),   .bcd(hours_bcd));
  hmt_bcd #(.W(MW)) u_min_bcd (.bin(minutes), .bcd(minutes_bcd));

  assign state_o = state;
endmodule

// File: rtl/hm_countdown_chk.sv
module hm_countdown_chk (
  input logic       clk,
  input logic       rst,
  input logic       step_press,
  input logic       bump_press,
  input logic [7:0] hours_bcd,
  input logic [7:0] minutes_bcd,
  input logic [1:0] state_o,
  input logic       done
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  always @(negedge clk) begin
    if (rst_q)
      reset_state_chk: assert (state_o == 2'd0 && !done && hours_bcd == 8'h00 && minutes_bcd == 8'h00);
  end

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    step_press && state_o == 2'd0 |=> state_o == 2'd1);

  // R5
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    state_o == 2'd3 && !step_press |=> $stable(hours_bcd) && $stable(minutes_bcd) && state_o == 2'd3);

  // R8
  done_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> state_o == 2'd3 && hours_bcd == 8'h00 && minutes_bcd == 8'h00);

  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    done && step_press |=> !done && state_o == 2'd0);

  // R3
  hour_cap_chk: assert property (@(posedge clk) disable iff (rst)
    hours_bcd == 8'h24 |-> minutes_bcd == 8'h00);
endmodule

bind hm_countdown hm_countdown_chk u_chk (.*);

// File: tb/hm_countdown_tb.sv
module hm_countdown_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc = 1'b0;
  logic adv = 1'b0;
  logic [7:0] hours_bcd, minutes_bcd;
  logic [1:0] state_o;
  logic done;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] h;
    logic [7:0] m;
    logic [1:0] s;
    logic       d;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hm_countdown #(.TICK_CYCLES(TICK)) u_dut (
    .clk(clk), .rst(rst), .step_press(cyc), .bump_press(adv),
    .hours_bcd(hours_bcd), .minutes_bcd(minutes_bcd), .state_o(state_o), .done(done)
  );

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic expect_out(input logic [7:0] h, input logic [7:0] m,
                            input logic [1:0] s, input logic d, input string tag);
    exp_t e;
    e.h = h; e.m = m; e.s = s; e.d = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic chk_int(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic press(input logic c, input logic a);
    @(negedge clk);
    cyc = c; adv = a;
    @(negedge clk);
    cyc = 1'b0; adv = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (hours_bcd !== e.h || minutes_bcd !== e.m || state_o !== e.s || done !== e.d) begin
          fails++;
          $display("FAIL %s: got %h:%h st=%0d done=%0b expected %h:%h st=%0d done=%0b",
                   e.tag, hours_bcd, minutes_bcd, state_o, done, e.h, e.m, e.s, e.d);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int n;
    idle(3);
    rst = 1'b0;
    expect_out(8'h00, 8'h00, 2'd0, 1'b0, "R1 reset state");

    // hour setting and wrap
    for (int i = 0; i < 3; i++) press(0, 1);
    expect_out(8'h03, 8'h00, 2'd0, 1'b0, "R3 hours advance");
    for (int i = 0; i < 21; i++) press(0, 1);
    expect_out(8'h24, 8'h00, 2'd0, 1'b0, "R3 R13 hours at limit");
    press(0, 1);
    expect_out(8'h00, 8'h00, 2'd0, 1'b0, "R3 hours wrap");
    press(0, 1); press(0, 1);
    press(1, 0);
    expect_out(8'h02, 8'h00, 2'd1, 1'b0, "R2 to minute setting");

    // minute setting and wrap
    for (int i = 0; i < 59; i++) press(0, 1);
    expect_out(8'h02, 8'h59, 2'd1, 1'b0, "R4 R13 minutes at 59");
    press(0, 1);
    expect_out(8'h02, 8'h00, 2'd1, 1'b0, "R4 minutes wrap");
    for (int i = 0; i < 30; i++) press(0, 1);
    press(1, 0);
    expect_out(8'h02, 8'h30, 2'd2, 1'b0, "R2 to counting");
    press(1, 0);
    expect_out(8'h02, 8'h30, 2'd3, 1'b0, "R10 pause without done");
    press(0, 1);
    expect_out(8'h02, 8'h30, 2'd3, 1'b0, "R5 bump ignored halted");
    press(1, 0);
    expect_out(8'h02, 8'h30, 2'd0, 1'b0, "R10 remaining kept as preset");

    // forcing minutes at the hour limit
    for (int i = 0; i < 22; i++) press(0, 1);
    expect_out(8'h24, 8'h00, 2'd0, 1'b0, "R3 limit forces minutes");
    press(1, 0);
    press(0, 1);
    expect_out(8'h24, 8'h00, 2'd1, 1'b0, "R4 minutes capped at limit");
    press(1, 0);
    press(0, 1);
    expect_out(8'h24, 8'h00, 2'd2, 1'b0, "R5 bump ignored counting");
    press(1, 0); press(1, 0);
    press(0, 1);
    expect_out(8'h00, 8'h00, 2'd0, 1'b0, "R3 wrap from limit");

    // simultaneous step and bump
    press(1, 1);
    expect_out(8'h01, 8'h00, 2'd1, 1'b0, "R12 bump hours while stepping");
    press(1, 1);
    expect_out(8'h01, 8'h01, 2'd2, 1'b0, "R12 bump minutes while starting");

    // count rate and hour borrow
    for (int k = 1; k <= 120 * TICK; k++) begin
      @(negedge clk);
      if (k == 60 * TICK - 1)  expect_out(8'h01, 8'h01, 2'd2, 1'b0, "R6 before first minute");
      if (k == 60 * TICK)      expect_out(8'h01, 8'h00, 2'd2, 1'b0, "R6 first minute drop");
      if (k == 120 * TICK - 1) expect_out(8'h01, 8'h00, 2'd2, 1'b0, "R7 before borrow");
      if (k == 120 * TICK)     expect_out(8'h00, 8'h59, 2'd2, 1'b0, "R7 hour borrow");
    end
    press(1, 0);
    expect_out(8'h00, 8'h59, 2'd3, 1'b0, "R10 pause mid count");
    idle(20);
    expect_out(8'h00, 8'h59, 2'd3, 1'b0, "R10 time holds halted");
    press(1, 0);
    expect_out(8'h00, 8'h59, 2'd0, 1'b0, "R10 back to hour setting");

    // expiry latency
    press(1, 0);
    press(0, 1); press(0, 1);
    expect_out(8'h00, 8'h01, 2'd1, 1'b0, "R4 preset one minute");
    press(1, 0);
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk_int(n, (60 + 59) * TICK + 1, "R8 expiry latency");
    expect_out(8'h00, 8'h00, 2'd3, 1'b1, "R8 expired state");
    press(0, 1);
    expect_out(8'h00, 8'h00, 2'd3, 1'b1, "R5 bump ignored after expiry");
    press(1, 0);
    expect_out(8'h00, 8'h00, 2'd0, 1'b0, "R9 done cleared");

    // step press coinciding with expiry
    press(1, 0);
    press(0, 1);
    press(1, 0);
    idle((60 + 59) * TICK - 1);
    press(1, 0);
    expect_out(8'h00, 8'h00, 2'd3, 1'b1, "R11 expiry wins over step");
    press(1, 0);
    expect_out(8'h00, 8'h00, 2'd0, 1'b0, "R9 clear after coincident expiry");

    idle(3);
    summary();
  end
endmodule